// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses by walking a single-level table in memory. The table has one 32-bit entry per 4 KiB page and is indexed directly by the virtual page number, so the 4 GiB virtual space needs 2^20 entries (4 MiB). For each accepted request the block issues exactly one entry read. When the response returns, it either builds the physical address from the entry's frame bits and the request's page offset, or it reports a fault and steers the access to a protection address.

Clients present a virtual address on a valid/ready request port and receive a single-cycle response pulse. Entry reads go out on a minimal memory read port: a one-cycle read strobe with an address, answered later by an acknowledge that carries the data. The table base is held in a register inside the block and loaded from a write strobe. While that register holds zero, the block does no table lookup and returns the virtual address unchanged. The protection address is a plain configuration input.

Top module: `flat_xlate`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_rd_valid and flt_pulse are 0. The table base register is 0.
- R2: While the table base register is 0, an accepted request produces no memory read. rsp_valid rises in the cycle after acceptance with rsp_pa equal to the request VA, and with rsp_fault and rsp_nonsec both 0.
- R3: With a non-zero base, mem_rd_valid is high for exactly the one cycle after acceptance. In that cycle mem_rd_addr equals base + VA[31:12]*4, wrapping modulo 2^32.
- R4: At most one entry read is outstanding. req_ready stays 0 from acceptance until the cycle after the response pulse, and each request produces exactly one read strobe.
- R5: An entry with bit 1 set is valid. rsp_pa is then the entry with bits [11:0] cleared, OR'd with VA[11:0], and rsp_fault is 0.
- R6: For a valid entry, rsp_nonsec equals entry bit 3. On a fault, rsp_nonsec is 0.
- R7: An entry with bit 1 clear, including an all-zero entry, gives rsp_fault = 1. rsp_pa is then prot_addr with bits [6:0] cleared, which is a 128-byte aligned address.
- R8: flt_pulse is high for the single response cycle of a faulting request, and flt_va carries that request's VA. flt_pulse stays 0 for valid translations.
- R9: rsp_valid is a one-cycle pulse in the cycle after mem_rd_ack is sampled high. Data offered while no acknowledge is given has no effect on the result.
- R10: Entry bits 0, 2 and 4 to 11 do not affect rsp_pa, rsp_fault or rsp_nonsec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Load strobe for the table base register |
| base_wr_data | input | 32 | New table base value |
| prot_addr | input | 32 | Protection address; bits [6:0] are ignored |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Physical address or protection address |
| rsp_fault | output | 1 | Response is a translation fault |
| rsp_nonsec | output | 1 | Non-secure flag of the entry |
| flt_pulse | output | 1 | One-cycle fault event |
| flt_va | output | 32 | Virtual address that faulted |
| mem_rd_valid | output | 1 | Entry read strobe |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_ack | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry value |

## Verification
The bound checker watches the following on every cycle:
- the read strobe lasts one cycle and only one read is in flight while req_ready is low;
- the response is a single-cycle pulse;
- a valid response keeps the page offset of the accepted VA;
- a fault response carries the aligned protection address, with the non-secure flag clear and a fault pulse naming the accepted VA.

Only the directed scenarios can show the exact entry address, including wrap-around of the base sum. They also show the frame bits taken from the entry, the flag bits that are ignored, and the bypass taken while the base is zero. The timing of the response against read latencies of different lengths is also shown only by the scenarios.

// File: rtl/flat_xlate_pkg.sv
// Shared types for the flat table translator.
// Assumes a 32-bit address space for both virtual and physical sides.
package flat_xlate_pkg;

    localparam int unsigned XL_AW = 32;

    // Walk sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xl_state_e;

    // Registered translation outcome
    typedef struct packed {
        logic [XL_AW-1:0] pa;
        logic             fault;
        logic             nonsec;
    } xl_result_t;

endpackage

// File: rtl/flat_xlate_seq.sv
// Walk sequencer: accepts one request at a time, issues a single read
// strobe, waits for the acknowledge and presents a one-cycle response.
// Assumes the acknowledge arrives no earlier than the cycle after the strobe.
module flat_xlate_seq
    import flat_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      bypass,
    input  logic      mem_ack,
    output xl_state_e state_o,
    output logic      accept_o,
    output logic      capture_o
);

    xl_state_e state_q, state_d;

    assign accept_o  = (state_q == ST_IDLE) && req_valid;
    assign capture_o = (state_q == ST_WAIT) && mem_ack;
    assign state_o   = state_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = bypass ? ST_DONE : ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (mem_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/flat_xlate_addr.sv
// Entry address generator: base plus page number times entry size.
// Assumes the sum wraps modulo 2^AW.
module flat_xlate_addr #(
    parameter int unsigned AW         = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ENTRY_LOG2 = 2
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] page_idx;

    // Page number scaled to an entry byte offset, added to the base
    always_comb begin
        page_idx = va >> PAGE_SHIFT;
        addr     = base + (page_idx << ENTRY_LOG2);
    end

endmodule

// File: rtl/flat_xlate_decode.sv
// Entry decoder: checks the valid flag, merges frame and page offset,
// or picks the aligned protection address on a fault.
// Assumes the frame occupies the entry bits above PAGE_SHIFT.
module flat_xlate_decode #(
    parameter int unsigned AW         = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned VALID_BIT  = 1,
    parameter int unsigned NONSEC_BIT = 3,
    parameter int unsigned PROT_ALIGN = 7
) (
    input  logic [AW-1:0] entry,
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] prot,
    output logic [AW-1:0] pa,
    output logic          fault,
    output logic          nonsec
);

    localparam logic [AW-1:0] OFF_MASK  = AW'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [AW-1:0] PROT_MASK = AW'((64'd1 << PROT_ALIGN) - 64'd1);

    logic ok;

    // Valid check and address formation
    always_comb begin
        ok     = entry[VALID_BIT];
        fault  = !ok;
        nonsec = ok && entry[NONSEC_BIT];
        if (ok) pa = (entry & ~OFF_MASK) | (va & OFF_MASK);
        else    pa = prot & ~PROT_MASK;
    end

endmodule

// File: rtl/flat_xlate.sv
// Flat page table translator top: holds the table base, latches the
// request, drives the read port and registers the response.
// Assumes one client and one memory port; no caching of entries.
module flat_xlate
    import flat_xlate_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ENTRY_LOG2 = 2,
    parameter int unsigned VALID_BIT  = 1,
    parameter int unsigned NONSEC_BIT = 3,
    parameter int unsigned PROT_ALIGN = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                base_wr_en,
    input  logic [XL_AW-1:0]    base_wr_data,
    input  logic [XL_AW-1:0]    prot_addr,
    input  logic                req_valid,
    input  logic [XL_AW-1:0]    req_va,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [XL_AW-1:0]    rsp_pa,
    output logic                rsp_fault,
    output logic                rsp_nonsec,
    output logic                flt_pulse,
    output logic [XL_AW-1:0]    flt_va,
    output logic                mem_rd_valid,
    output logic [XL_AW-1:0]    mem_rd_addr,
    input  logic                mem_rd_ack,
    input  logic [XL_AW-1:0]    mem_rd_data
);

    localparam int unsigned AW = XL_AW;

    logic [AW-1:0] base_q;
    logic [AW-1:0] va_q;
    logic [AW-1:0] rd_addr_q;
    logic [AW-1:0] addr_calc;
    logic [AW-1:0] dec_pa;
    logic          dec_fault;
    logic          dec_nonsec;
    logic          bypass;
    logic          accept;
    logic          capture;
    xl_state_e     state;
    xl_result_t    res_q;

    assign bypass = (base_q == '0);

    flat_xlate_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bypass    (bypass),
        .mem_ack   (mem_rd_ack),
        .state_o   (state),
        .accept_o  (accept),
        .capture_o (capture)
    );

    flat_xlate_addr #(
        .AW         (AW),
        .PAGE_SHIFT (PAGE_SHIFT),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_addr (
        .base (base_q),
        .va   (req_va),
        .addr (addr_calc)
    );

    flat_xlate_decode #(
        .AW         (AW),
        .PAGE_SHIFT (PAGE_SHIFT),
        .VALID_BIT  (VALID_BIT),
        .NONSEC_BIT (NONSEC_BIT),
        .PROT_ALIGN (PROT_ALIGN)
    ) u_dec (
        .entry  (mem_rd_data),
        .va     (va_q),
        .prot   (prot_addr),
        .pa     (dec_pa),
        .fault  (dec_fault),
        .nonsec (dec_nonsec)
    );

    // Table base register, zero out of reset (zero means bypass)
    always_ff @(posedge clk) begin
        if (!rst_n)          base_q <= '0;
        else if (base_wr_en) base_q <= base_wr_data;
    end

    // Request capture: VA and entry address latched on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            rd_addr_q <= '0;
        end else if (accept) begin
            va_q      <= req_va;
            rd_addr_q <= addr_calc;
        end
    end

    // Result register: identity on bypass, decoded entry on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (accept && bypass) begin
            res_q.pa     <= req_va;
            res_q.fault  <= 1'b0;
            res_q.nonsec <= 1'b0;
        end else if (capture) begin
            res_q.pa     <= dec_pa;
            res_q.fault  <= dec_fault;
            res_q.nonsec <= dec_nonsec;
        end
    end

    assign req_ready    = (state == ST_IDLE);
    assign mem_rd_valid = (state == ST_FETCH);
    assign mem_rd_addr  = rd_addr_q;
    assign rsp_valid    = (state == ST_DONE);
    assign rsp_pa       = res_q.pa;
    assign rsp_fault    = res_q.fault;
    assign rsp_nonsec   = res_q.nonsec;
    assign flt_pulse    = (state == ST_DONE) && res_q.fault;
    assign flt_va       = va_q;

endmodule

// File: rtl/flat_xlate_chk.sv
// Protocol checker for flat_xlate, attached by bind.
// Tracks the last accepted VA on its own to relate responses to requests.
module flat_xlate_chk #(
    parameter int unsigned AW         = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned PROT_ALIGN = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_va,
    input logic          mem_rd_valid,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_pa,
    input logic          rsp_fault,
    input logic          rsp_nonsec,
    input logic          flt_pulse,
    input logic [AW-1:0] flt_va,
    input logic [AW-1:0] prot_addr
);

    localparam logic [AW-1:0] OFF_MASK  = AW'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [AW-1:0] PROT_MASK = AW'((64'd1 << PROT_ALIGN) - 64'd1);

    logic [AW-1:0] cap_va;

    // Shadow copy of the accepted VA
    always_ff @(posedge clk) begin
        if (!rst_n)                      cap_va <= '0;
        else if (req_valid && req_ready) cap_va <= req_va;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_rd_valid && !flt_pulse));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    assert_busy_on_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || rsp_valid) |-> !req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> ((rsp_pa & OFF_MASK) == (cap_va & OFF_MASK)));

    assert_prot_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == (prot_addr & ~PROT_MASK)));

    assert_fault_secure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_nonsec);

    assert_fault_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pulse |-> (rsp_valid && rsp_fault && flt_va == cap_va));

    assert_fault_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> flt_pulse);

endmodule

bind flat_xlate flat_xlate_chk #(
    .AW         (flat_xlate_pkg::XL_AW),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PROT_ALIGN (PROT_ALIGN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .mem_rd_valid (mem_rd_valid),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_fault    (rsp_fault),
    .rsp_nonsec   (rsp_nonsec),
    .flt_pulse    (flt_pulse),
    .flt_va       (flt_va),
    .prot_addr    (prot_addr)
);

// File: tb/tb_flat_xlate.sv
// Directed bench for flat_xlate: one task per scenario.
module tb_flat_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [31:0] prot_addr = 32'h0000_90FF;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic        rsp_nonsec;
    logic        flt_pulse;
    logic [31:0] flt_va;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = 32'hDEAD_BEEF;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    flat_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .prot_addr(prot_addr),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_nonsec(rsp_nonsec), .flt_pulse(flt_pulse), .flt_va(flt_va),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    // R1: idle outputs right after reset
    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        chk(flt_pulse == 1'b0, "R1", "flt_pulse", 32'(flt_pulse), 32'd0);
    endtask

    // R2: zero base returns the VA with no memory read
    task automatic t_bypass(input logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2", "bypass rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_pa == va, "R2", "bypass pa", rsp_pa, va);
        chk(!rsp_fault && !rsp_nonsec, "R2", "bypass flags",
            {30'd0, rsp_fault, rsp_nonsec}, 32'd0);
        chk(mem_rd_valid == 1'b0, "R2", "bypass no read", 32'(mem_rd_valid), 32'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready, "R9", "bypass pulse ends",
            32'(rsp_valid), 32'd0);
    endtask

    // R3 R4 R5 R6 R7 R8 R9: one full walk with a chosen read latency
    task automatic run_xlate(input logic [31:0] va, input logic [31:0] entry,
                             input int lat, input logic [31:0] exp_addr,
                             input logic [31:0] exp_pa, input bit exp_flt,
                             input bit exp_ns, input string rq);
        @(negedge clk);
        chk(req_ready == 1'b1, "R4", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_rd_valid == 1'b1, "R3", "read strobe", 32'(mem_rd_valid), 32'd1);
        chk(mem_rd_addr == exp_addr, "R3", "entry address", mem_rd_addr, exp_addr);
        chk(req_ready == 1'b0, "R4", "busy on fetch", 32'(req_ready), 32'd0);
        for (int i = 1; i < lat; i++) begin
            @(negedge clk);
            chk(!mem_rd_valid && !req_ready, "R4", "single outstanding",
                {30'd0, mem_rd_valid, req_ready}, 32'd0);
            chk(rsp_valid == 1'b0, "R9", "no early response", 32'(rsp_valid), 32'd0);
        end
        @(negedge clk);
        mem_rd_ack = 1'b1; mem_rd_data = entry;
        @(negedge clk);
        mem_rd_ack = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
        chk(rsp_valid == 1'b1, "R9", "response after ack", 32'(rsp_valid), 32'd1);
        chk(rsp_pa == exp_pa, rq, "physical address", rsp_pa, exp_pa);
        chk(rsp_fault == exp_flt, rq, "fault flag", 32'(rsp_fault), 32'(exp_flt));
        chk(rsp_nonsec == exp_ns, "R6", "nonsec flag", 32'(rsp_nonsec), 32'(exp_ns));
        chk(flt_pulse == exp_flt, "R8", "fault pulse", 32'(flt_pulse), 32'(exp_flt));
        if (exp_flt) chk(flt_va == va, "R8", "fault va", flt_va, va);
        @(negedge clk);
        chk(!rsp_valid && !flt_pulse, "R9", "pulse one cycle",
            {30'd0, rsp_valid, flt_pulse}, 32'd0);
        chk(req_ready == 1'b1, "R4", "ready after response", 32'(req_ready), 32'd1);
    endtask

    task automatic t_valid_map();
        // R5 R6: frame plus offset, nonsec bit 3 set
        run_xlate(32'h0000_3ABC, 32'h4567_800A, 1, 32'h8000_000C,
                  32'h4567_8ABC, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_ignored_bits();
        // R10: bits 0, 2, 4..11 set, bit 3 clear; last page index
        run_xlate(32'hFFFF_F123, 32'h1111_1FF7, 2, 32'h803F_FFFC,
                  32'h1111_1123, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_invalid();
        // R7 R8: bit 1 clear with bit 3 set still faults, nonsec forced 0
        run_xlate(32'h0004_5010, 32'h2222_2008, 1, 32'h8000_0114,
                  32'h0000_9080, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_zero_entry();
        // R7: all-zero entry faults
        run_xlate(32'h0010_0004, 32'h0000_0000, 3, 32'h8000_0400,
                  32'h0000_9080, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_long_latency();
        // R9: slow memory, garbage data ignored until acknowledge
        run_xlate(32'h0000_0FFF, 32'h0ABC_D002, 6, 32'h8000_0000,
                  32'h0ABC_DFFF, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_base_wrap();
        // R3: base sum wraps modulo 2^32
        set_base(32'hFFFF_F000);
        run_xlate(32'h0000_2000, 32'h0000_5002, 1, 32'hFFFF_F008,
                  32'h0000_5000, 1'b0, 1'b0, "R3");
        run_xlate(32'h0040_0777, 32'h7000_000A, 1, 32'h0000_0000,
                  32'h7000_0777, 1'b0, 1'b1, "R3");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass(32'h1234_5678);   // R1: base still zero after reset
        set_base(32'h8000_0000);
        t_valid_map();
        t_ignored_bits();
        t_invalid();
        t_zero_entry();
        t_long_latency();
        t_base_wrap();
        set_base(32'h0000_0000);
        t_bypass(32'hCAFE_0123);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule